// File: doc/BRIEF.md
# Parallel Nonvolatile Memory Programming Port

This block is the test-mode front end through which an external programmer writes the on-chip byte-wide program memory and reads it back. The programmer works over an 8-bit bus. Two select lines pick a target holding register. A level-sensitive strobe fills the selected register, and an active-low write enable starts a program pulse. The upper and lower halves of the byte address sit in separate registers that keep their contents between operations. A programmer that walks through a page therefore only rewrites the lower byte.

A grouped mode programs four bytes at once. It is active while the program-mode input is high and the group select is low. In this mode the four bytes share one address except in bits 1:0. Each byte is loaded into its own lane, selected by the low two address bits. One pulse then writes all four lanes. The pulse length is a cycle count and is set by a parameter. The memory array is outside this block and is reached through a combinational read port and a write port with byte lane enables.

Top module: `nvm_prog_port`

## Requirements
- R1: After reset, busy, bus_oe and mem_wr are low, and both address registers hold zero. A verify read right after reset returns the byte at address 0.
- R2: When prog_mode and rd_stb are high and busy is low, the register chosen by lsel takes bus_in on every clock edge: 2'b01 selects the lower address byte and 2'b10 selects the upper address byte. The two may be loaded in either order. The byte address is {upper[ADDR_W-9:0], lower}.
- R3: The upper address register keeps its value across program and verify operations. A new lower byte alone addresses the next byte in the same page.
- R4: With group select high, a high-to-low step of wr_en_n (while prog_mode is high and busy is low) captures bus_in as the data byte and starts one program pulse at the latched address. The pulse writes a single byte lane, lane = lower[1:0].
- R5: A verify is requested by prog_mode high, wr_en_n high, rd_stb high, lsel 2'b00 and busy low. One cycle after the request, bus_oe is high and bus_out holds the memory byte at the latched address. When no verify is requested, bus_oe is low one cycle later.
- R6: In grouped mode (prog_mode high, group select low), lsel 2'b11 with rd_stb high loads bus_in into data lane lower[1:0].
- R7: In grouped mode, a wr_en_n falling step writes all four lanes with a single pulse. The write goes to word address {upper[ADDR_W-9:0], lower[7:2]} with byte enables 4'b1111. Lane n holds the byte for address bits 1:0 = n.
- R8: After a grouped program, a verify without reloading returns the byte for the lane whose lower byte was loaded last. Reloading a lower byte makes any other lane verifiable.
- R9: While busy is high, loads into every register and further wr_en_n falling steps have no effect.
- R10: If bit ADDR_W-8 of the upper register is set (an address in the extra rows), a wr_en_n falling step starts no pulse and writes nothing.
- R11: busy is high for exactly PULSE_CYC cycles, beginning the cycle after the wr_en_n step is sampled. mem_wr is high for one cycle, the last busy cycle. The default of 20000 cycles is 100 µs at 200 MHz.
- R12: With prog_mode low, no register loads, no pulse starts and bus_oe stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_mode | input | 1 | Programming mode enable |
| grp_n | input | 1 | Group select, low selects four-byte mode |
| lsel | input | 2 | Register select: 01 lower, 10 upper, 11 data, 00 none/verify |
| rd_stb | input | 1 | Level-sensitive load / read strobe |
| wr_en_n | input | 1 | Active-low write enable, falling step starts a pulse |
| bus_in | input | 8 | Bus value driven by the programmer |
| bus_out | output | 8 | Verify data toward the bus |
| bus_oe | output | 1 | Bus drive enable for verify |
| busy | output | 1 | Program pulse in progress |
| mem_rd_addr | output | ADDR_W | Byte read address toward the array |
| mem_rd_data | input | 8 | Byte read data from the array |
| mem_wr | output | 1 | One-cycle write commit at the end of the pulse |
| mem_wr_addr | output | ADDR_W-2 | Word address of the write |
| mem_wr_data | output | 32 | Four data lanes, lane n in bits 8n+7:8n |
| mem_wr_be | output | 4 | Byte lane enables |

## Verification
Each register load is visible at the edge that samples rd_stb high. For that reason the bench drives at the falling clock edge and issues a verify only on a later cycle. Verify data is registered once, so the bench raises the strobe at one falling edge and samples bus_oe and bus_out at the next. busy is due at the first falling edge after the wr_en_n step. The bench counts busy cycles one per falling edge and expects exactly PULSE_CYC. It counts commit pulses at rising edges and compares that count before and after the stimuli that must start nothing. The address sweeps cover every upper page and both load orders. Expected bytes come from a shadow array that the bench updates from its own stimulus.

// File: rtl/nvm_prog_pkg.sv
// Shared definitions for the programming port.
// Assumes a four-lane grouped write, indexed by address bits 1:0.
package nvm_prog_pkg;
    typedef enum logic [1:0] {
        SEL_NONE = 2'b00,
        SEL_LO   = 2'b01,
        SEL_HI   = 2'b10,
        SEL_DATA = 2'b11
    } lsel_e;

    localparam int LANES  = 4;
    localparam int LANE_W = 8;
endpackage

// File: rtl/nvm_addr_latch.sv
// Upper and lower address byte registers.
// Each loads from the bus while its enable is high. Both hold otherwise.
// Assumes the caller gates the enables (mode, strobe, busy).
module nvm_addr_latch (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ld_lo,
    input  logic       ld_hi,
    input  logic [7:0] din,
    output logic [7:0] lo_q,
    output logic [7:0] hi_q
);
    // Lower address byte: follow the bus while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)     lo_q <= '0;
        else if (ld_lo) lo_q <= din;
    end

    // Upper address byte: follow the bus while enabled, hold across operations.
    always_ff @(posedge clk) begin
        if (!rst_n)     hi_q <= '0;
        else if (ld_hi) hi_q <= din;
    end
endmodule

// File: rtl/nvm_data_latch.sv
// Four data lane registers. The lane picked by idx loads din when ld is high.
// Assumes at most one lane is loaded per cycle.
module nvm_data_latch
    import nvm_prog_pkg::*;
#(
    parameter int NLANE = LANES,
    localparam int IDX_W = $clog2(NLANE)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ld,
    input  logic [IDX_W-1:0]        idx,
    input  logic [LANE_W-1:0]       din,
    output logic [NLANE*LANE_W-1:0] lanes_q
);
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        // One lane: load when selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lanes_q[g*LANE_W +: LANE_W] <= '0;
            else if (ld && (idx == IDX_W'(g)))
                lanes_q[g*LANE_W +: LANE_W] <= din;
        end
    end
endmodule

// File: rtl/nvm_pulse_timer.sv
// Program pulse timer. A start makes busy high for PULSE_CYC cycles.
// done marks the last busy cycle. Assumes start only arrives while idle.
module nvm_pulse_timer #(
    parameter int PULSE_CYC = 20000,
    localparam int CNT_W = $clog2(PULSE_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    logic [CNT_W-1:0] cnt_q;

    // Load the count on start, then count down to zero and release busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (!busy && start) begin
            busy  <= 1'b1;
            cnt_q <= CNT_W'(PULSE_CYC - 1);
        end else if (busy) begin
            if (cnt_q == '0) busy <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    // Last busy cycle.
    always_comb done = busy && (cnt_q == '0);

    // R11: busy only drops after the count has run out.
    a_r11_full_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(cnt_q == '0));

    // R9: a start never lands on a running pulse.
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
endmodule

// File: rtl/nvm_prog_port.sv
// Programming port top.
// Decodes register loads from lsel/rd_stb, detects the wr_en_n falling step,
// launches the pulse timer and registers verify data toward the bus.
// Assumes 9 <= ADDR_W <= 15: the lower byte is address bits 7:0, and upper bit
// ADDR_W-8 marks the extra rows.
module nvm_prog_port
    import nvm_prog_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int PULSE_CYC = 20000,
    localparam int HI_USED  = ADDR_W - 8,
    localparam int WADDR_W  = ADDR_W - 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     prog_mode,
    input  logic                     grp_n,
    input  logic [1:0]               lsel,
    input  logic                     rd_stb,
    input  logic                     wr_en_n,
    input  logic [7:0]               bus_in,
    output logic [7:0]               bus_out,
    output logic                     bus_oe,
    output logic                     busy,
    output logic [ADDR_W-1:0]        mem_rd_addr,
    input  logic [7:0]               mem_rd_data,
    output logic                     mem_wr,
    output logic [WADDR_W-1:0]       mem_wr_addr,
    output logic [LANES*LANE_W-1:0]  mem_wr_data,
    output logic [LANES-1:0]         mem_wr_be
);
    logic [7:0]         lo_q, hi_q;
    logic               quad, ld_ok, ld_lo, ld_hi, ld_dq, dl_ld;
    logic               we_q, we_fall, extra, start, verify;
    logic [LANES-1:0]   be_q;
    logic [WADDR_W-1:0] waddr_q;

    // Load enables and mode decode.
    always_comb begin
        quad   = prog_mode && !grp_n;
        ld_ok  = prog_mode && rd_stb && !busy;
        ld_lo  = ld_ok && (lsel == SEL_LO);
        ld_hi  = ld_ok && (lsel == SEL_HI);
        ld_dq  = ld_ok && (lsel == SEL_DATA) && quad;
        extra  = hi_q[HI_USED];
        start  = we_fall && prog_mode && !busy && !extra;
        dl_ld  = ld_dq || (start && !quad);
        verify = prog_mode && wr_en_n && rd_stb && (lsel == SEL_NONE) && !busy;
    end

    // Previous write enable level, for falling-step detection.
    always_ff @(posedge clk) begin
        if (!rst_n) we_q <= 1'b1;
        else        we_q <= wr_en_n;
    end

    always_comb we_fall = we_q && !wr_en_n;

    nvm_addr_latch u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .ld_lo (ld_lo),
        .ld_hi (ld_hi),
        .din   (bus_in),
        .lo_q  (lo_q),
        .hi_q  (hi_q)
    );

    nvm_data_latch #(.NLANE(LANES)) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld      (dl_ld),
        .idx     (lo_q[1:0]),
        .din     (bus_in),
        .lanes_q (mem_wr_data)
    );

    nvm_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .done  (mem_wr)
    );

    // Capture the lane enables and word address of the pulse being started.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            be_q    <= '0;
            waddr_q <= '0;
        end else if (start) begin
            be_q    <= quad ? {LANES{1'b1}} : (LANES'(1) << lo_q[1:0]);
            waddr_q <= {hi_q[HI_USED-1:0], lo_q[7:2]};
        end
    end

    always_comb begin
        mem_wr_be   = be_q;
        mem_wr_addr = waddr_q;
        mem_rd_addr = {hi_q[HI_USED-1:0], lo_q};
    end

    // Registered verify drive toward the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_oe  <= 1'b0;
            bus_out <= '0;
        end else begin
            bus_oe  <= verify;
            bus_out <= verify ? mem_rd_data : '0;
        end
    end

    // R4: a pulse begins only after a sampled falling step in program mode.
    a_r4_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(!we_q ? 1'b0 : (!wr_en_n && prog_mode)));

    // R9: address registers hold while a pulse runs.
    a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(hi_q) && $stable(lo_q)));

    // R10: no pulse is started from the extra rows.
    a_r10_no_extra: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(hi_q[HI_USED]));

    // R7: a commit enables one lane or all four.
    a_r7_lane_shape: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (($countones(mem_wr_be) == 1) || (mem_wr_be == {LANES{1'b1}})));

    // R5: the bus is never driven in a cycle that follows a busy cycle's request.
    a_r5_no_drive_busy: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> $past(!busy && prog_mode));
endmodule

// File: tb/nvm_prog_port_test.sv
`timescale 1ns/1ps
module nvm_prog_port_test;
    localparam int AW   = 10;
    localparam int PC   = 8;
    localparam int MEMN = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prog_mode, grp_n, rd_stb, wr_en_n;
    logic [1:0] lsel;
    logic [7:0] bus_in, bus_out, mem_rd_data;
    logic bus_oe, busy, mem_wr;
    logic [AW-1:0] mem_rd_addr;
    logic [AW-3:0] mem_wr_addr;
    logic [31:0] mem_wr_data;
    logic [3:0] mem_wr_be;

    logic [7:0] mem [MEMN];
    logic [7:0] exp_mem [MEMN];
    int checks = 0;
    int fails = 0;
    int wr_count = 0;

    always #2.5 clk = ~clk;

    nvm_prog_port #(.ADDR_W(AW), .PULSE_CYC(PC)) uut (
        .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .grp_n(grp_n),
        .lsel(lsel), .rd_stb(rd_stb), .wr_en_n(wr_en_n), .bus_in(bus_in),
        .bus_out(bus_out), .bus_oe(bus_oe), .busy(busy),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr(mem_wr), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_wr_be(mem_wr_be)
    );

    // Array model: erased on reset, lane writes on commit.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEMN; i++) mem[i] <= 8'hFF;
        end else if (mem_wr) begin
            wr_count <= wr_count + 1;
            for (int l = 0; l < 4; l++)
                if (mem_wr_be[l]) mem[{mem_wr_addr, 2'(l)}] <= mem_wr_data[l*8 +: 8];
        end
    end
    assign mem_rd_data = mem[mem_rd_addr];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    function automatic logic [7:0] pat(input int a, input int salt);
        return 8'((a * 7 + salt * 29 + 3) & 255);
    endfunction

    task automatic load(input logic [1:0] sel, input logic [7:0] v);
        @(negedge clk);
        lsel = sel; bus_in = v; rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0; lsel = 2'b00;
    endtask

    // Drive a falling step of wr_en_n, count busy cycles.
    task automatic pulse(input logic [7:0] d, input string req, input bit expect_start);
        int n;
        @(negedge clk);
        bus_in = d; wr_en_n = 1'b0;
        @(negedge clk);
        chk(req, busy, expect_start);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        if (expect_start) chk("R11 pulse length", n, PC);
        wr_en_n = 1'b1;
    endtask

    task automatic verify(input string req, input logic [7:0] exp);
        @(negedge clk);
        lsel = 2'b00; rd_stb = 1'b1;
        @(negedge clk);
        chk(req, {bus_oe, bus_out}, {1'b1, exp});
        rd_stb = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        fails++; checks++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        int w0;
        int base;
        prog_mode = 1'b1; grp_n = 1'b1; lsel = 2'b00; rd_stb = 1'b0;
        wr_en_n = 1'b1; bus_in = 8'h00;
        for (int i = 0; i < MEMN; i++) exp_mem[i] = 8'hFF;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 busy", busy, 0);
        chk("R1 oe", bus_oe, 0);
        chk("R1 wr", wr_count, 0);
        verify("R1 addr0", exp_mem[0]);

        // R2 R3 R4 R11: single-byte sweep over all pages, both load orders.
        for (int h = 0; h < 4; h++) begin
            for (int k = 0; k < 16; k++) begin
                int a;
                a = h * 256 + k * 17;
                if (k == 0 && (h % 2 == 1)) begin
                    load(2'b01, 8'(k * 17));
                    load(2'b10, 8'(h));
                end else if (k == 0) begin
                    load(2'b10, 8'(h));
                    load(2'b01, 8'(k * 17));
                end else begin
                    load(2'b01, 8'(k * 17)); // R3: upper kept
                end
                pulse(pat(a, 0), "R4 start", 1'b1);
                exp_mem[a] = pat(a, 0);
                verify("R4 R5 verify after program", exp_mem[a]);
            end
        end
        chk("R4 commit count", wr_count, 64);

        // R2 R5: read back every programmed byte with reloaded addresses.
        for (int h = 0; h < 4; h++) begin
            load(2'b10, 8'(h));
            for (int k = 0; k < 16; k++) begin
                load(2'b01, 8'(k * 17));
                verify("R2 R5 readback", exp_mem[h * 256 + k * 17]);
            end
        end

        // R6 R7 R8: grouped mode, page 2, 16 words.
        grp_n = 1'b0;
        load(2'b10, 8'h02);
        for (int w = 0; w < 16; w++) begin
            base = 2 * 256 + 8'h40 + w * 4;
            for (int b = 0; b < 4; b++) begin
                load(2'b01, 8'(8'h40 + w * 4 + b));
                load(2'b11, pat(base + b, 1));
                exp_mem[base + b] = pat(base + b, 1);
            end
            w0 = wr_count;
            pulse(8'h00, "R7 start", 1'b1);
            chk("R7 single pulse", wr_count - w0, 1);
            verify("R8 lane3 first", exp_mem[base + 3]);
            for (int b = 0; b < 3; b++) begin
                load(2'b01, 8'(8'h40 + w * 4 + b));
                verify("R7 R8 lane reload", exp_mem[base + b]);
            end
        end
        grp_n = 1'b1;

        // R9: loads and a second step during a pulse are ignored.
        load(2'b10, 8'h03);
        load(2'b01, 8'h05);
        w0 = wr_count;
        @(negedge clk);
        bus_in = 8'h5A; wr_en_n = 1'b0;
        @(negedge clk);
        chk("R9 busy", busy, 1);
        lsel = 2'b01; bus_in = 8'h99; rd_stb = 1'b1;
        @(negedge clk);
        lsel = 2'b10; bus_in = 8'h00;
        @(negedge clk);
        rd_stb = 1'b0; lsel = 2'b00; wr_en_n = 1'b1;
        @(negedge clk);
        wr_en_n = 1'b0;
        while (busy) @(negedge clk);
        wr_en_n = 1'b1;
        repeat (PC + 2) @(negedge clk);
        chk("R9 one commit", wr_count - w0, 1);
        exp_mem[3 * 256 + 5] = 8'h5A;
        verify("R9 address held", exp_mem[3 * 256 + 5]);

        // R10: extra rows start nothing.
        load(2'b10, 8'h04);
        w0 = wr_count;
        pulse(8'h11, "R10 no start", 1'b0);
        repeat (PC + 2) @(negedge clk);
        chk("R10 no commit", wr_count - w0, 0);

        // R12: program mode low.
        load(2'b10, 8'h01);
        load(2'b01, 8'h22);
        prog_mode = 1'b0;
        load(2'b01, 8'h33);
        load(2'b10, 8'h00);
        w0 = wr_count;
        pulse(8'h77, "R12 no start", 1'b0);
        @(negedge clk);
        rd_stb = 1'b1;
        @(negedge clk);
        chk("R12 no drive", bus_oe, 0);
        rd_stb = 1'b0;
        chk("R12 no commit", wr_count - w0, 0);
        prog_mode = 1'b1;
        verify("R12 loads ignored", exp_mem[256 + 8'h22]);
        @(negedge clk);
        chk("R5 oe drops", bus_oe, 0);

        finish_run();
    end
endmodule